// File: doc/BRIEF.md
# I2C Register-Pointer Memory Target

This block is an I2C target that gives a bus controller access to a bank of 256 byte-wide registers. It samples SCL and SDA through a small synchroniser chain running on the system clock. It drives SDA only through an open-drain enable: when `sda_oe` is high, the pad pulls the line low. It recognises START, repeated START and STOP, and it answers only to its own 7-bit device address, 0x68.

A write transfer works as follows. The first byte after the address byte loads an internal register pointer. Every later byte is stored at the pointer, and the pointer then steps by one. A read transfer returns bytes starting at the pointer, which also steps by one after each byte. The pointer survives STOP and repeated START. A controller can therefore select a register with a short write and then read from it after a repeated START. It can also simply read on from where the last access stopped.

Top module: `i2cmem_target`

## Requirements
- R1: The target acknowledges the address bytes 0xD0 (write, R/W bit 0) and 0xD1 (read, R/W bit 1). It does this by holding `sda_oe` high for the whole ninth SCL clock that follows the address.
- R2: After an address byte whose upper seven bits are not 0x68, the target leaves `sda_oe` low and does not acknowledge. All later bytes are then ignored, and nothing in the register bank or pointer changes, until the next START or STOP.
- R3: In a write transfer, the first data byte is loaded into the register pointer. Each later byte is stored at the pointer, which then steps by one. The target acknowledges every written byte during its ninth clock.
- R4: In a read transfer, the target sends the byte at the pointer MSB first, then steps the pointer by one. This works across a repeated START. Each bit is placed on SDA during the SCL low phase that comes before the clock that samples it.
- R5: The register pointer wraps from 255 to 0 when it steps, in both writes and reads.
- R6: The pointer keeps its value across STOP and START. A read with no index byte continues from the last position.
- R7: When the controller does not acknowledge a read byte (SDA high in the ninth clock), the target releases SDA. It then drives nothing further until the next START or STOP.
- R8: A START or STOP seen at any bit position clears the bit count and the transfer state. A byte that was only partly clocked is discarded.
- R9: `sda_oe` is low during reset and afterwards changes only while SCL is low.
- R10: The target works when each SCL high phase and each low phase lasts at least 6 system clock cycles. The controller must change SDA no earlier than 1 cycle after SCL falls. A 400 kHz bus therefore needs only a system clock of a few MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level sampled from the bus |
| sda_i | input | 1 | SDA level sampled from the bus (wired-AND of all drivers) |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
Every response of the target is timed from an SCL edge. A change on `sda_oe` comes SYNC_STAGES + 1 clocks after the SCL fall that causes it: two synchroniser stages plus the state register. A byte or bit taken from SDA is registered SYNC_STAGES + 1 clocks after the SCL rise. The bench-side controller reads SDA in the middle of each SCL high phase, at least one full phase after the fall that set the data. It places its own SDA changes in the middle of the low phase. Every sample therefore falls well clear of the target's update cycle, even with the shortest 6-cycle phases. A negative-edge monitor counts any `sda_oe` change while SCL is high, and it also counts any drive at all during the ignored and released stretches.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    localparam int BYTE_W   = 8;
    localparam int BITCNT_W = $clog2(BYTE_W + 1);
    localparam logic [BITCNT_W-1:0] CNT_FULL = BITCNT_W'(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_SKIP
    } xfer_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    // upper seven bits of an address byte against the device address
    function automatic logic addr_hit(input byte_t b, input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

    // bit to present after n bits of b have already been sent, MSB first
    function automatic logic tx_bit(input byte_t b, input logic [BITCNT_W-1:0] n);
        byte_t sh;
        sh = b << n;
        return sh[BYTE_W-1];
    endfunction

endpackage

// File: rtl/i2cmem_sync.sv
module i2cmem_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] r;
            always_ff @(posedge clk) begin
                if (rst) r <= '1;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            localparam int CHAIN_W = STAGES * WIDTH;
            logic [CHAIN_W-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[CHAIN_W-WIDTH-1:0], d};
            end
            assign q = chain[CHAIN_W-1 -: WIDTH];
        end
    endgenerate

endmodule

// File: rtl/i2cmem_cond.sv
module i2cmem_cond
    import i2cmem_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);

    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        evt.scl_rise = scl_s & ~scl_d;
        evt.scl_fall = ~scl_s & scl_d;
        evt.start    = scl_s & scl_d & sda_d & ~sda_s;
        evt.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2cmem_regs.sv
module i2cmem_regs
    import i2cmem_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  byte_t            wdata,
    input  logic [IDX_W-1:0] raddr,
    output byte_t            rdata
);

    localparam int DEPTH = 1 << IDX_W;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/i2cmem_target.sv
module i2cmem_target
    import i2cmem_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         IDX_W       = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    logic [1:0] pins_s;
    logic       scl_s;
    logic       sda_s;
    bus_evt_t   evt;

    i2cmem_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_i, sda_i}),
        .q   (pins_s)
    );
    assign scl_s = pins_s[1];
    assign sda_s = pins_s[0];

    i2cmem_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .evt   (evt)
    );

    xfer_state_e         state_q, state_d;
    logic [BITCNT_W-1:0] bit_cnt_q, cnt_d;
    byte_t               shreg_q, sh_d;
    byte_t               tx_q, tx_d;
    logic [IDX_W-1:0]    ptr_q, ptr_d;
    logic                idx_pend_q, pend_d;
    logic                rd_mode_q, rd_d;
    logic                mst_ack_q, mack_d;
    logic                sda_oe_q, oe_d;
    logic                mem_we;
    byte_t               rd_byte;

    i2cmem_regs #(.IDX_W(IDX_W)) u_regs (
        .clk   (clk),
        .we    (mem_we),
        .waddr (ptr_q),
        .wdata (shreg_q),
        .raddr (ptr_q),
        .rdata (rd_byte)
    );

    always_comb begin
        state_d = state_q;
        cnt_d   = bit_cnt_q;
        sh_d    = shreg_q;
        tx_d    = tx_q;
        ptr_d   = ptr_q;
        pend_d  = idx_pend_q;
        rd_d    = rd_mode_q;
        mack_d  = mst_ack_q;
        oe_d    = sda_oe_q;
        mem_we  = 1'b0;

        if (evt.start) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
            oe_d    = 1'b0;
            pend_d  = 1'b1;
        end else if (evt.stop) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            oe_d    = 1'b0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_WR_BYTE: begin
                    if (evt.scl_rise && bit_cnt_q != CNT_FULL) begin
                        sh_d  = {shreg_q[BYTE_W-2:0], sda_s};
                        cnt_d = bit_cnt_q + 1'b1;
                    end
                    if (evt.scl_fall && bit_cnt_q == CNT_FULL) begin
                        if (state_q == ST_ADDR) begin
                            if (addr_hit(shreg_q, DEV_ADDR)) begin
                                state_d = ST_ADDR_ACK;
                                oe_d    = 1'b1;
                                rd_d    = shreg_q[0];
                            end else begin
                                state_d = ST_SKIP;
                                oe_d    = 1'b0;
                            end
                        end else begin
                            state_d = ST_WR_ACK;
                            oe_d    = 1'b1;
                            if (idx_pend_q) begin
                                ptr_d  = IDX_W'(shreg_q);
                                pend_d = 1'b0;
                            end else begin
                                mem_we = 1'b1;
                                ptr_d  = ptr_q + 1'b1;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt.scl_fall) begin
                        cnt_d = '0;
                        if (rd_mode_q) begin
                            state_d = ST_RD_BYTE;
                            tx_d    = rd_byte;
                            oe_d    = ~rd_byte[BYTE_W-1];
                            ptr_d   = ptr_q + 1'b1;
                        end else begin
                            state_d = ST_WR_BYTE;
                            oe_d    = 1'b0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (evt.scl_fall) begin
                        state_d = ST_WR_BYTE;
                        cnt_d   = '0;
                        oe_d    = 1'b0;
                    end
                end
                ST_RD_BYTE: begin
                    if (evt.scl_rise) cnt_d = bit_cnt_q + 1'b1;
                    if (evt.scl_fall) begin
                        if (bit_cnt_q == CNT_FULL) begin
                            state_d = ST_RD_ACK;
                            oe_d    = 1'b0;
                        end else begin
                            oe_d = ~tx_bit(tx_q, bit_cnt_q);
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (evt.scl_rise) mack_d = ~sda_s;
                    if (evt.scl_fall) begin
                        cnt_d = '0;
                        if (mst_ack_q) begin
                            state_d = ST_RD_BYTE;
                            tx_d    = rd_byte;
                            oe_d    = ~rd_byte[BYTE_W-1];
                            ptr_d   = ptr_q + 1'b1;
                        end else begin
                            state_d = ST_SKIP;
                            oe_d    = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            bit_cnt_q  <= '0;
            shreg_q    <= '0;
            tx_q       <= '0;
            ptr_q      <= '0;
            idx_pend_q <= 1'b0;
            rd_mode_q  <= 1'b0;
            mst_ack_q  <= 1'b0;
            sda_oe_q   <= 1'b0;
        end else begin
            state_q    <= state_d;
            bit_cnt_q  <= cnt_d;
            shreg_q    <= sh_d;
            tx_q       <= tx_d;
            ptr_q      <= ptr_d;
            idx_pend_q <= pend_d;
            rd_mode_q  <= rd_d;
            mst_ack_q  <= mack_d;
            sda_oe_q   <= oe_d;
        end
    end

    assign sda_oe = sda_oe_q;

    // R1
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADDR_ACK) |-> sda_oe_q);

    // R2
    foreign_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.scl_fall && state_q == ST_ADDR && bit_cnt_q == CNT_FULL &&
         shreg_q[BYTE_W-1:1] != DEV_ADDR) |=> (state_q == ST_SKIP && !sda_oe_q));

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R7
    nack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RD_ACK && evt.scl_fall && !mst_ack_q) |=>
        (state_q == ST_SKIP && !sda_oe_q));

    // R8
    start_reset_chk: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state_q == ST_ADDR && bit_cnt_q == '0 && !sda_oe_q));

    // R8
    stop_reset_chk: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state_q == ST_IDLE && !sda_oe_q));

    // R9
    oe_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe_q) && !$past(evt.start) && !$past(evt.stop)) |-> !$past(scl_s));

endmodule

// File: tb/i2cmem_target_tb.sv
module i2cmem_target_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    i2cmem_target u_dut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    int half = 4;
    int viol = 0;
    int oe_seen = 0;
    logic oe_prev = 1'b0;
    logic done = 1'b0;
    logic [7:0] pat [8];

    // {index, data} pairs: single write, then readback through repeated START
    localparam logic [15:0] VEC [6] = '{
        {8'h00, 8'hA5}, {8'h01, 8'h5A}, {8'h7F, 8'h3C},
        {8'h80, 8'hC3}, {8'hFE, 8'h0F}, {8'hFF, 8'hF0}
    };

    always @(negedge clk) begin
        if (!rst) begin
            if (sda_oe !== oe_prev && scl_m) viol++;
            if (sda_oe) oe_seen++;
        end
        oe_prev = sda_oe;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        wait_clk(half); sda_m = 1'b1;
        wait_clk(half); scl_m = 1'b1;
        wait_clk(half); sda_m = 1'b0;
        wait_clk(half); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clk(half); sda_m = 1'b0;
        wait_clk(half); scl_m = 1'b1;
        wait_clk(half); sda_m = 1'b1;
        wait_clk(2 * half);
    endtask

    task automatic bit_out(input logic b);
        wait_clk(half); sda_m = b;
        wait_clk(half); scl_m = 1'b1;
        wait_clk(2 * half); scl_m = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        wait_clk(half); sda_m = 1'b1;
        wait_clk(half); scl_m = 1'b1;
        wait_clk(half); ack = ~sda_bus;
        wait_clk(half); scl_m = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] d, input logic give_ack);
        for (int i = 7; i >= 0; i--) begin
            wait_clk(half); sda_m = 1'b1;
            wait_clk(half); scl_m = 1'b1;
            wait_clk(half); d[i] = sda_bus;
            wait_clk(half); scl_m = 1'b0;
        end
        wait_clk(half); sda_m = ~give_ack;
        wait_clk(half); scl_m = 1'b1;
        wait_clk(2 * half); scl_m = 1'b0;
    endtask

    task automatic txn_write(input logic [7:0] idx, input int n, input string tag);
        logic ack;
        bus_start();
        write_byte(8'hD0, ack); check({tag, " R1 write address ack"}, ack, 1'b1);
        write_byte(idx, ack);   check({tag, " R3 index ack"}, ack, 1'b1);
        for (int k = 0; k < n; k++) begin
            write_byte(pat[k], ack); check({tag, " R3 data ack"}, ack, 1'b1);
        end
        bus_stop();
    endtask

    task automatic read_tail(input int n, input string tag);
        logic ack;
        logic [7:0] d;
        write_byte(8'hD1, ack); check({tag, " R1 read address ack"}, ack, 1'b1);
        for (int k = 0; k < n; k++) begin
            read_byte(d, k != n - 1);
            check({tag, " R4 read data"}, d, pat[k]);
        end
    endtask

    task automatic txn_read_from(input logic [7:0] idx, input int n, input string tag);
        logic ack;
        bus_start();
        write_byte(8'hD0, ack); check({tag, " R1 address ack"}, ack, 1'b1);
        write_byte(idx, ack);   check({tag, " R3 index ack"}, ack, 1'b1);
        bus_start();
        read_tail(n, tag);
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        logic all_high;

        wait_clk(5);
        check("R9 oe low in reset", sda_oe, 1'b0);
        rst = 1'b0;
        wait_clk(10);
        check("R9 oe low after reset", sda_oe, 1'b0);

        // vector table: write one byte, read it back
        for (int v = 0; v < 6; v++) begin
            pat[0] = VEC[v][7:0];
            txn_write(VEC[v][15:8], 1, "vec");
            txn_read_from(VEC[v][15:8], 1, "vec");
        end

        // R3 / R4 burst
        pat[0] = 8'h11; pat[1] = 8'h22; pat[2] = 8'h33; pat[3] = 8'h44;
        txn_write(8'h40, 4, "burst");
        txn_read_from(8'h40, 4, "burst");

        // R5 wrap in write and read
        pat[0] = 8'hAB; pat[1] = 8'hCD; pat[2] = 8'hEF;
        txn_write(8'hFE, 3, "R5 wrap write");
        txn_read_from(8'hFE, 3, "R5 wrap read");
        pat[0] = 8'hEF;
        txn_read_from(8'h00, 1, "R5 landed at 0");

        // R6 pointer persists across STOP
        pat[0] = 8'h61; pat[1] = 8'h62; pat[2] = 8'h63; pat[3] = 8'h64;
        txn_write(8'h20, 4, "R6 fill");
        txn_write(8'h20, 0, "R6 select");
        bus_start(); read_tail(1, "R6 bare 1"); bus_stop();
        check("R6 bare read 1", 1'b1, 1'b1);
        pat[0] = 8'h62;
        bus_start(); read_tail(1, "R6 bare 2 R6"); bus_stop();

        // R2 foreign address ignored
        oe_seen = 0;
        bus_start();
        write_byte(8'hA0, ack); check("R2 no ack foreign addr", ack, 1'b0);
        write_byte(8'h40, ack); check("R2 no ack after foreign", ack, 1'b0);
        write_byte(8'h99, ack); check("R2 no ack data", ack, 1'b0);
        bus_stop();
        check("R2 oe never driven", oe_seen, 0);
        pat[0] = 8'h11;
        txn_read_from(8'h40, 1, "R2 memory untouched");

        // R7 release after controller NACK
        pat[0] = 8'h11;
        bus_start();
        write_byte(8'hD0, ack);
        write_byte(8'h40, ack);
        bus_start();
        read_tail(1, "R7 nack byte");
        oe_seen = 0;
        all_high = 1'b1;
        for (int k = 0; k < 9; k++) begin
            wait_clk(half); sda_m = 1'b1;
            wait_clk(half); scl_m = 1'b1;
            wait_clk(half); all_high = all_high & sda_bus;
            wait_clk(half); scl_m = 1'b0;
        end
        check("R7 sda stays released", all_high, 1'b1);
        check("R7 no drive after nack", oe_seen, 0);
        bus_stop();
        pat[0] = 8'h22;
        txn_read_from(8'h41, 1, "R7 recovery");

        // R8 abort mid-byte by STOP, then by repeated START
        pat[0] = 8'h77;
        txn_write(8'h30, 1, "R8 seed");
        bus_start();
        write_byte(8'hD0, ack);
        write_byte(8'h30, ack);
        for (int k = 0; k < 4; k++) bit_out(1'b1);
        bus_stop();
        txn_read_from(8'h30, 1, "R8 partial byte discarded");
        bus_start();
        for (int k = 0; k < 4; k++) bit_out(1'b1);
        bus_start();
        write_byte(8'hD0, ack); check("R8 address after aborted start", ack, 1'b1);
        write_byte(8'h30, ack); check("R8 index after aborted start", ack, 1'b1);
        bus_start();
        read_tail(1, "R8 readback");
        bus_stop();

        // R10 shortest phases
        half = 3;
        pat[0] = 8'h96; pat[1] = 8'h69;
        txn_write(8'h90, 2, "R10 fast write");
        txn_read_from(8'h90, 2, "R10 fast read");
        half = 4;

        check("R9 oe changes only with SCL low", viol, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule